// File: doc/BRIEF.md
# Low-Power Mode and Reset Qualification Controller

This block sits beside the core of a small 8-bit microcontroller and decides which clocks run. Software asks for a light sleep, in which the instruction engine halts while timers, serial logic and interrupt logic keep ticking. It can also ask for a deep sleep, in which every clock stops, including the oscillator. The block turns these requests into three enables for downstream clock gating cells: one for the CPU, one for the peripherals and one for the oscillator. It also reports the current request bits back.

The same block qualifies the raw external reset pin. The pin is synchronised and counted in oscillator periods. An internal reset is produced only when the pin has been seen high for two whole machine cycles of 12 periods each while the oscillator runs. A free-running prescaler marks machine-cycle boundaries and starts again from zero when reset ends. The block also blocks RAM writes in the short gap after a reset-driven exit from light sleep, while port writes go through. Separately, when the first lock bit is set, it holds the external-fetch strap at the value it had during reset.

`clk` is the block's own always-running reference. Its registers stay clocked even when `osc_en` is low, so that it can see the reset pin and restart the oscillator. `por` is the synchronous power-on reset of the block itself.

Top module: `lpm_ctrl`

## Requirements
- R1: `rst_int` goes high only after `rst_pin` has been sampled high on 24 consecutive `clk` edges while the oscillator runs. A pulse held for H edges gives exactly max(0, H-23) cycles of `rst_int`, and a shorter pulse has no effect.
- R2: `mc_tick` pulses once every 12 oscillator cycles. After `rst_int` falls, the first pulse is seen 11 cycles after the first cycle in which `rst_int` is low.
- R3: A mode write with bit 0 set and bit 1 clear enters light sleep on the next cycle. In light sleep `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1 and `mode_o`=2'b01.
- R4: In light sleep, any interrupt line that is pending with its enable bit set returns the block to run mode on the next cycle and clears `mode_o`. A pending line whose enable bit is clear has no effect.
- R5: A mode write with bit 1 set enters deep sleep. In deep sleep all three enables are 0 and `mode_o`=2'b10, and interrupts, enabled or not, change nothing.
- R6: When bits 0 and 1 are written together, deep sleep wins: `mode_o`=2'b10 and `osc_en`=0.
- R7: Only the reset pin leaves deep sleep. Once the synchronised pin is seen, `osc_en` returns while `cpu_clk_en` stays 0 until `rst_int` is asserted. After reset, `mode_o`=2'b00 and `cpu_clk_en`=1.
- R8: If the reset pin ends light sleep, the CPU clock resumes at once. `ram_we_o` is forced low until `rst_int` takes over, while `port_we_o` still follows `port_we_i`.
- R9: While `rst_int` is high, `ram_we_o` and `port_we_o` are 0 and the mode bits are cleared. After reset the block is in run mode with all enables high.
- R10: With `lock1`=1, `ea_eff` holds the `ea_pin` level captured during the last reset. With `lock1`=0, `ea_eff` follows `ea_pin` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| por | input | 1 | Synchronous active-high power-on reset of the block |
| rst_pin | input | 1 | Raw external reset pin, asynchronous |
| mode_wr | input | 1 | Strobe writing the mode request bits |
| mode_wdata | input | 2 | Bit 0 requests light sleep, bit 1 requests deep sleep |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| ram_we_i | input | 1 | CPU RAM write strobe |
| port_we_i | input | 1 | CPU port write strobe |
| lock1 | input | 1 | First lock bit programmed |
| ea_pin | input | 1 | External-fetch strap level |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| rst_int | output | 1 | Qualified internal reset |
| mc_tick | output | 1 | Machine-cycle boundary pulse |
| mode_o | output | 2 | Current request bits, same layout as `mode_wdata` |
| ram_we_o | output | 1 | Qualified RAM write strobe |
| port_we_o | output | 1 | Qualified port write strobe |
| ea_eff | output | 1 | Effective external-fetch strap |

## Verification
The assertions check several properties on every cycle. Deep sleep is never left without the synchronised reset pin. An enabled interrupt always ends light sleep. The internal reset never rises unless the pin was held and the oscillator was running. The CPU clock is never enabled without the oscillator. The prescaler never emits back-to-back ticks. Only the bench scenarios can show the exact cycle counts: the 24-edge qualification threshold swept across it, the 11/12-cycle tick phase after reset, the per-line sweep of interrupt wake-ups, the write-blocking window after an idle exit by reset, and the strap capture.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

    localparam int MODE_IDLE_BIT = 0;
    localparam int MODE_PD_BIT   = 1;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PDOWN  = 2'd2,
        ST_PDWAKE = 2'd3
    } lpm_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } clk_gate_t;

    function automatic clk_gate_t gates_of(lpm_state_e st);
        clk_gate_t g;
        g.cpu = (st == ST_RUN);
        g.per = (st == ST_RUN) || (st == ST_IDLE);
        g.osc = (st != ST_PDOWN);
        return g;
    endfunction

    function automatic logic [1:0] mode_bits_of(lpm_state_e st);
        logic [1:0] m;
        m = 2'b00;
        m[MODE_IDLE_BIT] = (st == ST_IDLE);
        m[MODE_PD_BIT]   = (st == ST_PDOWN) || (st == ST_PDWAKE);
        return m;
    endfunction

endpackage

// File: rtl/lpm_rst_qual.sv
`timescale 1ns/1ps
module lpm_rst_qual #(
    parameter int MC_LEN = 12,
    parameter int RST_MC = 2
) (
    input  logic clk,
    input  logic por,
    input  logic pin_raw,
    input  logic osc_run,
    output logic pin_s,
    output logic rst_q
);
    localparam int TARGET = MC_LEN * RST_MC;
    localparam int CW     = $clog2(TARGET + 1);
    localparam logic [CW-1:0] TGT = CW'(TARGET);

    logic          s1, s2;
    logic [CW-1:0] held;

    always_ff @(posedge clk) begin
        if (por) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            held <= '0;
        end else begin
            s1 <= pin_raw;
            s2 <= s1;
            if (!s2)
                held <= '0;
            else if (osc_run && held != TGT)
                held <= held + 1'b1;
        end
    end

    assign pin_s = s2;
    assign rst_q = (held == TGT);

    // R1
    rst_rise_needs_pin_chk: assert property (@(posedge clk) disable iff (por)
        $rose(rst_q) |-> $past(pin_s));
    // R1
    rst_drop_on_pin_low_chk: assert property (@(posedge clk) disable iff (por)
        !pin_s |=> !rst_q);
    // R1
    rst_frozen_osc_chk: assert property (@(posedge clk) disable iff (por)
        (!osc_run && !rst_q) |=> !rst_q);
endmodule

// File: rtl/lpm_prescaler.sv
`timescale 1ns/1ps
module lpm_prescaler #(
    parameter int MC_LEN = 12
) (
    input  logic clk,
    input  logic por,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = $clog2(MC_LEN);
    localparam logic [PW-1:0] LAST = PW'(MC_LEN - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (por || clr)
            phase <= '0;
        else if (run)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    assign tick = run && (phase == LAST);

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (por)
        phase <= LAST);
    // R2
    no_double_tick_chk: assert property (@(posedge clk) disable iff (por)
        tick |=> !tick);
endmodule

// File: rtl/lpm_mode_fsm.sv
`timescale 1ns/1ps
module lpm_mode_fsm
    import lpm_pkg::*;
#(
    parameter int N_IRQ = 5
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst_q,
    input  logic             pin_s,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    output lpm_state_e       state,
    output logic             ram_blk
);
    logic irq_hit;
    assign irq_hit = |(irq_pend & irq_en);

    always_ff @(posedge clk) begin
        if (por || rst_q) begin
            state   <= ST_RUN;
            ram_blk <= 1'b0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (mode_wr && mode_wdata[MODE_PD_BIT])
                        state <= ST_PDOWN;
                    else if (mode_wr && mode_wdata[MODE_IDLE_BIT])
                        state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (pin_s)
                        state <= ST_RUN;
                    else if (irq_hit)
                        state <= ST_RUN;
                end
                ST_PDOWN: begin
                    if (pin_s)
                        state <= ST_PDWAKE;
                end
                ST_PDWAKE: begin
                    if (!pin_s)
                        state <= ST_PDOWN;
                end
                default: state <= ST_RUN;
            endcase

            if (state == ST_IDLE && pin_s)
                ram_blk <= 1'b1;
            else if (!pin_s)
                ram_blk <= 1'b0;
        end
    end

    // R5
    pd_exit_only_by_pin_chk: assert property (@(posedge clk) disable iff (por)
        (state == ST_PDOWN && !pin_s && !rst_q) |=> state == ST_PDOWN);
    // R4
    idle_irq_wake_chk: assert property (@(posedge clk) disable iff (por)
        (state == ST_IDLE && irq_hit && !rst_q) |=> state == ST_RUN);
    // R8
    blk_only_in_run_chk: assert property (@(posedge clk) disable iff (por)
        $rose(ram_blk) |-> (state == ST_RUN && $past(state == ST_IDLE)));
endmodule

// File: rtl/lpm_ctrl.sv
`timescale 1ns/1ps
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ  = 5,
    parameter int MC_LEN = 12,
    parameter int RST_MC = 2
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst_pin,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             ram_we_i,
    input  logic             port_we_i,
    input  logic             lock1,
    input  logic             ea_pin,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             rst_int,
    output logic             mc_tick,
    output logic [1:0]       mode_o,
    output logic             ram_we_o,
    output logic             port_we_o,
    output logic             ea_eff
);
    lpm_state_e state;
    clk_gate_t  gates;
    logic       pin_s, rst_q, ram_blk, ea_lat;

    assign gates = gates_of(state);

    lpm_rst_qual #(.MC_LEN(MC_LEN), .RST_MC(RST_MC)) u_rstq (
        .clk     (clk),
        .por     (por),
        .pin_raw (rst_pin),
        .osc_run (gates.osc),
        .pin_s   (pin_s),
        .rst_q   (rst_q)
    );

    lpm_prescaler #(.MC_LEN(MC_LEN)) u_psc (
        .clk  (clk),
        .por  (por),
        .clr  (rst_q),
        .run  (gates.osc),
        .tick (mc_tick)
    );

    lpm_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
        .clk        (clk),
        .por        (por),
        .rst_q      (rst_q),
        .pin_s      (pin_s),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .irq_pend   (irq_pend),
        .irq_en     (irq_en),
        .state      (state),
        .ram_blk    (ram_blk)
    );

    always_ff @(posedge clk) begin
        if (por || rst_q)
            ea_lat <= ea_pin;
    end

    assign cpu_clk_en = gates.cpu;
    assign per_clk_en = gates.per;
    assign osc_en     = gates.osc;
    assign rst_int    = rst_q;
    assign mode_o     = mode_bits_of(state);
    assign ram_we_o   = ram_we_i && !ram_blk && !rst_q;
    assign port_we_o  = port_we_i && !rst_q;
    assign ea_eff     = lock1 ? ea_lat : ea_pin;

    // R9
    mode_clear_after_rst_chk: assert property (@(posedge clk) disable iff (por)
        rst_int |=> mode_o == 2'b00);
    // R7
    cpu_needs_osc_chk: assert property (@(posedge clk) disable iff (por)
        cpu_clk_en |-> osc_en);
    // R10
    ea_hold_chk: assert property (@(posedge clk) disable iff (por)
        (lock1 && !rst_int) |=> (!lock1 || $stable(ea_eff) || rst_int));
endmodule

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;
    localparam int N_IRQ = 5;

    logic clk = 1'b0;
    logic por, rst_pin, mode_wr, ram_we_i, port_we_i, lock1, ea_pin;
    logic [1:0] mode_wdata;
    logic [N_IRQ-1:0] irq_pend, irq_en;
    logic cpu_clk_en, per_clk_en, osc_en, rst_int, mc_tick, ram_we_o, port_we_o, ea_eff;
    logic [1:0] mode_o;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lpm_ctrl #(.N_IRQ(N_IRQ), .MC_LEN(12), .RST_MC(2)) dut (
        .clk(clk), .por(por), .rst_pin(rst_pin), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .irq_pend(irq_pend), .irq_en(irq_en),
        .ram_we_i(ram_we_i), .port_we_i(port_we_i), .lock1(lock1), .ea_pin(ea_pin),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .rst_int(rst_int), .mc_tick(mc_tick), .mode_o(mode_o),
        .ram_we_o(ram_we_o), .port_we_o(port_we_o), .ea_eff(ea_eff)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tk();
        @(posedge clk);
        #1;
    endtask

    task automatic write_mode(input logic [1:0] v);
        mode_wdata = v;
        mode_wr = 1'b1;
        tk();
        mode_wr = 1'b0;
        mode_wdata = 2'b00;
    endtask

    task automatic pulse(input int h, output int hicnt);
        hicnt = 0;
        rst_pin = 1'b1;
        for (int j = 0; j < h; j++) begin
            tk();
            if (rst_int) hicnt++;
        end
        rst_pin = 1'b0;
        for (int j = 0; j < 6; j++) begin
            tk();
            if (rst_int) hicnt++;
        end
    endtask

    task automatic pd_exit(input string req);
        bit seen = 0;
        bit early_cpu = 0;
        rst_pin = 1'b1;
        for (int j = 0; j < 40; j++) begin
            tk();
            if (j == 1) chk(osc_en == 1'b0, {req, " osc still off"}, osc_en, 0);
            if (j == 2) chk(osc_en == 1'b1, {req, " osc restarted"}, osc_en, 1);
            if (rst_int) seen = 1;
            if (!seen && cpu_clk_en) early_cpu = 1;
        end
        chk(seen, "R7 reset reached", seen, 1);
        chk(!early_cpu, "R7 cpu gated before reset", early_cpu, 0);
        rst_pin = 1'b0;
        repeat (4) tk();
        chk(mode_o == 2'b00, "R7 mode after reset", mode_o, 0);
        chk(cpu_clk_en == 1'b1, "R7 cpu after reset", cpu_clk_en, 1);
    endtask

    initial begin
        int hc, n;
        por = 1'b1; rst_pin = 0; mode_wr = 0; mode_wdata = 0; irq_pend = 0; irq_en = 0;
        ram_we_i = 0; port_we_i = 0; lock1 = 0; ea_pin = 0;
        repeat (3) tk();
        por = 1'b0;
        tk();
        chk({cpu_clk_en, per_clk_en, osc_en} == 3'b111, "R9 reset state enables",
            {cpu_clk_en, per_clk_en, osc_en}, 7);
        chk(mode_o == 2'b00 && !rst_int, "R9 reset state mode", mode_o, 0);

        // R1 sweep across the threshold
        for (int h = 18; h <= 29; h++) begin
            int exp_hi;
            pulse(h, hc);
            exp_hi = (h > 23) ? h - 23 : 0;
            chk(hc == exp_hi, $sformatf("R1 hold=%0d", h), hc, exp_hi);
        end

        // R2 prescaler phase after reset
        rst_pin = 1'b1;
        repeat (30) tk();
        rst_pin = 1'b0;
        n = 0;
        while (rst_int && n < 20) begin tk(); n++; end
        n = 0;
        while (!mc_tick && n < 30) begin tk(); n++; end
        chk(n == 11, "R2 first tick", n, 11);
        for (int k = 0; k < 3; k++) begin
            n = 0;
            tk(); n++;
            while (!mc_tick && n < 30) begin tk(); n++; end
            chk(n == 12, "R2 tick period", n, 12);
        end

        // R3 / R4 idle and per-line wake sweep
        for (int i = 0; i < N_IRQ; i++) begin
            for (int en = 0; en < 2; en++) begin
                write_mode(2'b01);
                chk({cpu_clk_en, per_clk_en, osc_en} == 3'b011, "R3 idle gates",
                    {cpu_clk_en, per_clk_en, osc_en}, 3);
                chk(mode_o == 2'b01, "R3 idle mode", mode_o, 1);
                irq_pend = N_IRQ'(1) << i;
                irq_en = en ? (N_IRQ'(1) << i) : ~(N_IRQ'(1) << i);
                tk();
                chk(cpu_clk_en == en[0], $sformatf("R4 line %0d en %0d", i, en), cpu_clk_en, en);
                chk(mode_o == (en ? 2'b00 : 2'b01), "R4 mode after irq", mode_o, en ? 0 : 1);
                if (!en) begin
                    irq_en = '1;
                    tk();
                end
                irq_pend = '0; irq_en = '0;
                tk();
            end
        end

        // R5 deep sleep ignores interrupts
        write_mode(2'b10);
        chk({cpu_clk_en, per_clk_en, osc_en} == 3'b000, "R5 pd gates",
            {cpu_clk_en, per_clk_en, osc_en}, 0);
        irq_pend = '1; irq_en = '1;
        repeat (5) tk();
        chk(mode_o == 2'b10 && !osc_en && !cpu_clk_en, "R5 pd irq ignored", mode_o, 2);
        irq_pend = '0; irq_en = '0;
        pd_exit("R7");

        // R6 both requested
        write_mode(2'b11);
        chk(mode_o == 2'b10, "R6 priority mode", mode_o, 2);
        chk(osc_en == 1'b0, "R6 priority osc", osc_en, 0);
        pd_exit("R6");

        // R8 idle exit by reset pin
        write_mode(2'b01);
        ram_we_i = 1; port_we_i = 1;
        rst_pin = 1'b1;
        repeat (3) tk();
        chk(cpu_clk_en == 1'b1 && !rst_int, "R8 cpu resumed", cpu_clk_en, 1);
        chk(ram_we_o == 1'b0, "R8 ram blocked", ram_we_o, 0);
        chk(port_we_o == 1'b1, "R8 port passes", port_we_o, 1);
        n = 0;
        while (!rst_int && n < 40) begin tk(); n++; end
        chk(rst_int && !ram_we_o && !port_we_o, "R9 writes held in reset",
            {ram_we_o, port_we_o}, 0);
        rst_pin = 1'b0;
        repeat (4) tk();
        chk(ram_we_o == 1'b1, "R8 ram after reset", ram_we_o, 1);
        ram_we_i = 0; port_we_i = 0;

        // R10 strap capture
        lock1 = 1; ea_pin = 1;
        pulse(30, hc);
        ea_pin = 0;
        tk();
        chk(ea_eff == 1'b1, "R10 latched strap", ea_eff, 1);
        lock1 = 0;
        #1;
        chk(ea_eff == 1'b0, "R10 live strap", ea_eff, 0);
        lock1 = 1;
        pulse(30, hc);
        ea_pin = 1;
        tk();
        chk(ea_eff == 1'b0, "R10 recaptured", ea_eff, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule